// File: doc/BRIEF.md
# Frame Header Status Inserter

This block sits inside an outbound frame formatter and decides what goes into the three header bytes that open every frame. A packet carries two frames. The frame builder steps through the header positions with a strobe and a slot index. Each time, the block returns one registered byte. In legacy mode every header byte is the fixed sync value 0x7F, so existing host software sees the traffic it expects.

When the host sets the status-mode control bit, the three header bytes carry a packed 24-bit status word instead. The word holds:

- the active receiver count;
- the upper bits of the transmit FIFO fill level;
- sticky transmit overflow and underflow flags;
- the receive bandwidth code;
- a bit that marks data captured while transmitting.

The mode and every status field are captured together at the first header position of a frame, so the three bytes describe one instant and a frame is never half legacy and half status. The receiver count shown is the value present at that first position. It may therefore trail a format change by one or two frames, but it never changes inside a frame.

Top module: `sync_status_inserter`

## Requirements
- R1: In a frame whose first header slot saw the status-mode bit low, every header byte emitted is 0x7F.
- R2: A strobe with slot index 0, 1 or 2 produces `out_valid` high one clock later, with `out_slot` equal to that index. Slot index 3 is ignored, so `out_valid` stays low on the next clock.
- R3: In status mode the 24-bit word is {receivers[23:20], depth[19:12], overflow[11], underflow[10], bandwidth[9:8], tx_active[7], zero[6:0]}. Slot 0 emits bits 23:16, slot 1 bits 15:8 and slot 2 bits 7:0.
- R4: The depth field equals bits 10:3 of the 11-bit fill count.
- R5: All status fields are sampled at the slot 0 strobe. Input changes after it do not alter slots 1 and 2 of the same frame.
- R6: The status-mode bit is sampled only at the slot 0 strobe. Changing it mid-frame has no effect until the next frame.
- R7: A one-cycle overflow or underflow event sets a sticky flag. The flag is reported as 1 in the next status-mode frame and is clear for the frame after that. An event in the same cycle as the slot 0 strobe is reported in that frame.
- R8: Sticky flags are not cleared by legacy-mode frames; they are held until a status-mode frame reports them.
- R9: After reset `out_valid` is low, and header slots issued before any slot 0 read 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | Header byte request from the frame builder |
| slot_idx | input | 2 | Header position 0..2 (3 is ignored) |
| status_en | input | 1 | Host status-mode control bit |
| rx_count | input | 4 | Active receiver count |
| fifo_fill | input | 11 | Transmit FIFO fill count |
| ovf_evt | input | 1 | Transmit FIFO overflow event pulse |
| unf_evt | input | 1 | Transmit FIFO underflow event pulse |
| rx_bw | input | 2 | Receive bandwidth code |
| ptt | input | 1 | Transmitter active |
| out_valid | output | 1 | Header byte valid |
| out_slot | output | 2 | Header position of the byte |
| out_byte | output | 8 | Header byte |

## Verification
A wrong latched mode shows at once: the next header byte would read 0x7F where a status byte is due, or the reverse. A wrong held snapshot shows no later than slots 1 and 2 of the same frame. A sticky flag that is lost or never cleared is invisible until the next status-mode frame, which may be many frames away if legacy frames come in between. For that reason the bench compares every output byte against a model on every clock, and places flag events just before, at and between frames.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam int RXC_W   = 4;
  localparam int DEPTH_W = 8;
  localparam int BW_W    = 2;
  localparam int WORD_W  = 24;
  localparam int HDR_BYTES = WORD_W / 8;
  localparam int PAD_W   = WORD_W - RXC_W - DEPTH_W - 2 - BW_W - 1;

  typedef struct packed {
    logic [RXC_W-1:0]   receivers;
    logic [DEPTH_W-1:0] depth;
    logic               overflow;
    logic               underflow;
    logic [BW_W-1:0]    bandwidth;
    logic               tx_active;
    logic [PAD_W-1:0]   pad;
  } status_word_t;

  function automatic status_word_t pack_status(
    input logic [RXC_W-1:0]   rx,
    input logic [DEPTH_W-1:0] dep,
    input logic               ov,
    input logic               un,
    input logic [BW_W-1:0]    bw,
    input logic               tx
  );
    status_word_t w;
    w.receivers = rx;
    w.depth     = dep;
    w.overflow  = ov;
    w.underflow = un;
    w.bandwidth = bw;
    w.tx_active = tx;
    w.pad       = '0;
    return w;
  endfunction

  function automatic logic [7:0] pick_byte(input status_word_t w, input logic [1:0] idx);
    logic [WORD_W-1:0] flat;
    flat = w;
    return flat[8*(HDR_BYTES-1-int'(idx)) +: 8];
  endfunction
endpackage

// File: rtl/ssi_sticky_flags.sv
module ssi_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clear,
  output logic [N-1:0] pend,
  output logic [N-1:0] seen
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (clear)  pend[i] <= 1'b0;
      else if (evt[i]) pend[i] <= 1'b1;
    end
    assign seen[i] = pend[i] | evt[i];
  end
endmodule

// File: rtl/ssi_snapshot.sv
module ssi_snapshot
  import ssi_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         mode_in,
  input  status_word_t word_in,
  output logic         mode_q,
  output status_word_t word_q,
  output logic         mode_cur,
  output status_word_t word_cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      word_q <= '0;
    end else if (capture) begin
      mode_q <= mode_in;
      word_q <= word_in;
    end
  end

  assign mode_cur = capture ? mode_in : mode_q;
  assign word_cur = capture ? word_in : word_q;
endmodule

// File: rtl/ssi_byte_mux.sv
module ssi_byte_mux
  import ssi_pkg::*;
#(
  parameter logic [7:0] SYNC_BYTE = 8'h7F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [1:0]   idx,
  input  logic         mode,
  input  status_word_t word,
  output logic         out_valid,
  output logic [1:0]   out_slot,
  output logic [7:0]   out_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_slot  <= '0;
      out_byte  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_slot <= idx;
        out_byte <= mode ? pick_byte(word, idx) : SYNC_BYTE;
      end
    end
  end
endmodule

// File: rtl/sync_status_inserter.sv
module sync_status_inserter
  import ssi_pkg::*;
#(
  parameter int         FILL_W    = 11,
  parameter logic [7:0] SYNC_BYTE = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic [1:0]        slot_idx,
  input  logic              status_en,
  input  logic [RXC_W-1:0]  rx_count,
  input  logic [FILL_W-1:0] fifo_fill,
  input  logic              ovf_evt,
  input  logic              unf_evt,
  input  logic [BW_W-1:0]   rx_bw,
  input  logic              ptt,
  output logic              out_valid,
  output logic [1:0]        out_slot,
  output logic [7:0]        out_byte
);
  localparam logic [1:0] LAST_SLOT = 2'(HDR_BYTES - 1);

  logic         frame_open;
  logic         slot_take;
  logic         report_now;
  logic [1:0]   pend_flags;
  logic [1:0]   seen_flags;
  logic         ovf_pend;
  logic         unf_pend;
  logic         frame_status_mode;
  logic         mode_cur;
  status_word_t live_word;
  status_word_t held_word;
  status_word_t word_cur;

  assign frame_open = slot_stb && (slot_idx == 2'd0);
  assign slot_take  = slot_stb && (slot_idx <= LAST_SLOT);
  assign report_now = frame_open && status_en;

  ssi_sticky_flags #(.N(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   ({unf_evt, ovf_evt}),
    .clear (report_now),
    .pend  (pend_flags),
    .seen  (seen_flags)
  );
  assign ovf_pend = pend_flags[0];
  assign unf_pend = pend_flags[1];

  assign live_word = pack_status(rx_count, fifo_fill[FILL_W-1 -: DEPTH_W],
                                 seen_flags[0], seen_flags[1], rx_bw, ptt);

  ssi_snapshot u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (frame_open),
    .mode_in  (status_en),
    .word_in  (live_word),
    .mode_q   (frame_status_mode),
    .word_q   (held_word),
    .mode_cur (mode_cur),
    .word_cur (word_cur)
  );

  ssi_byte_mux #(.SYNC_BYTE(SYNC_BYTE)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (slot_take),
    .idx       (slot_idx),
    .mode      (mode_cur),
    .word      (word_cur),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .out_byte  (out_byte)
  );
endmodule

// File: rtl/ssi_checker.sv
module ssi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_stb,
  input logic [1:0] slot_idx,
  input logic       status_en,
  input logic       ovf_evt,
  input logic       unf_evt,
  input logic       out_valid,
  input logic [1:0] out_slot,
  input logic [7:0] out_byte,
  input logic       frame_open,
  input logic       frame_status_mode,
  input logic       ovf_pend,
  input logic       unf_pend
);
  assert_legacy_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !frame_status_mode |-> out_byte == 8'h7F);

  assert_slot_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb && slot_idx != 2'd3 |=> out_valid && out_slot == $past(slot_idx));

  assert_slot3_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_stb && slot_idx != 2'd3) |=> !out_valid);

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && frame_status_mode && out_slot == 2'd2 |-> out_byte[6:0] == 7'd0);

  assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_open |=> $stable(frame_status_mode));

  assert_ovf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !(frame_open && status_en) |=> ovf_pend);

  assert_unf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt && !(frame_open && status_en) |=> unf_pend);

  assert_flags_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open && status_en |=> !ovf_pend && !unf_pend);

  assert_legacy_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pend && !(frame_open && status_en) |=> ovf_pend);
endmodule

bind sync_status_inserter ssi_checker u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .slot_stb          (slot_stb),
  .slot_idx          (slot_idx),
  .status_en         (status_en),
  .ovf_evt           (ovf_evt),
  .unf_evt           (unf_evt),
  .out_valid         (out_valid),
  .out_slot          (out_slot),
  .out_byte          (out_byte),
  .frame_open        (frame_open),
  .frame_status_mode (frame_status_mode),
  .ovf_pend          (ovf_pend),
  .unf_pend          (unf_pend)
);

// File: tb/sim_sync_status_inserter.sv
`timescale 1ns/1ps
module sim_sync_status_inserter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_stb = 1'b0;
  logic [1:0]  slot_idx = '0;
  logic        status_en = 1'b0;
  logic [3:0]  rx_count = '0;
  logic [10:0] fifo_fill = '0;
  logic        ovf_evt = 1'b0;
  logic        unf_evt = 1'b0;
  logic [1:0]  rx_bw = '0;
  logic        ptt = 1'b0;
  logic        out_valid;
  logic [1:0]  out_slot;
  logic [7:0]  out_byte;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_status_inserter u0 (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_idx(slot_idx),
    .status_en(status_en), .rx_count(rx_count), .fifo_fill(fifo_fill),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .rx_bw(rx_bw), .ptt(ptt),
    .out_valid(out_valid), .out_slot(out_slot), .out_byte(out_byte)
  );

  // behavioural reference model
  bit   m_ovf, m_unf, m_mode, m_vld;
  int   m_word;
  int   m_slot, m_byte;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ovf = 0; m_unf = 0; m_mode = 0; m_vld = 0;
      m_word = 0; m_slot = 0; m_byte = 0;
    end else begin
      m_vld = 0;
      if (slot_stb && slot_idx == 0) begin
        m_word = int'(rx_count) * 1048576 + (int'(fifo_fill) / 8) * 4096
               + int'(m_ovf | ovf_evt) * 2048 + int'(m_unf | unf_evt) * 1024
               + int'(rx_bw) * 256 + int'(ptt) * 128;
        m_mode = status_en;
        if (status_en) begin m_ovf = 0; m_unf = 0; end
        else begin m_ovf = m_ovf | ovf_evt; m_unf = m_unf | unf_evt; end
      end else begin
        m_ovf = m_ovf | ovf_evt;
        m_unf = m_unf | unf_evt;
      end
      if (slot_stb && slot_idx != 3) begin
        m_vld  = 1;
        m_slot = int'(slot_idx);
        m_byte = m_mode ? ((m_word >> (8 * (2 - int'(slot_idx)))) % 256) : 127;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (out_valid !== m_vld) begin
        mismatched++;
        $display("FAIL R2 out_valid actual=%0d expected=%0d", out_valid, m_vld);
      end else if (m_vld && (int'(out_slot) != m_slot || int'(out_byte) != m_byte)) begin
        mismatched++;
        $display("FAIL %s slot/byte actual=%0d/%02h expected=%0d/%02h",
                 m_mode ? "R3" : "R1", out_slot, out_byte, m_slot, m_byte);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic slot(input int idx, input bit ov, input bit un);
    slot_stb = 1; slot_idx = 2'(idx); ovf_evt = ov; unf_evt = un;
    @(negedge clk);
    slot_stb = 0; ovf_evt = 0; unf_evt = 0;
  endtask

  task automatic pulse(input bit ov, input bit un);
    ovf_evt = ov; unf_evt = un;
    @(negedge clk);
    ovf_evt = 0; unf_evt = 0;
  endtask

  task automatic set_fields(input int rx, input int fill, input int bw, input bit tx);
    rx_count = 4'(rx); fifo_fill = 11'(fill); rx_bw = 2'(bw); ptt = tx;
  endtask

  task automatic frame_expect(input string req, input int b0, input int b1, input int b2);
    slot(0, 0, 0); check(req, out_byte, b0);
    slot(1, 0, 0); check(req, out_byte, b1);
    slot(2, 0, 0); check(req, out_byte, b2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset valid", out_valid, 0);
    slot(1, 0, 0); check("R9 early slot", out_byte, 8'h7F);

    // R1: legacy frame with busy status inputs
    set_fields(4'hA, 11'h5A5, 2, 1);
    frame_expect("R1", 8'h7F, 8'h7F, 8'h7F);

    // R3, R4: status word AB 42 80
    status_en = 1;
    frame_expect("R3 R4", 8'hAB, 8'h42, 8'h80);

    // R5: inputs change after slot 0
    slot(0, 0, 0); check("R5 b0", out_byte, 8'hAB);
    set_fields(3, 11'h7FF, 1, 0);
    slot(1, 0, 0); check("R5 b1", out_byte, 8'h42);
    slot(2, 0, 0); check("R5 b2", out_byte, 8'h80);

    // R6: mode change mid-frame
    slot(0, 0, 0); check("R6 b0", out_byte, 8'h3F);
    status_en = 0;
    slot(1, 0, 0); check("R6 held status", out_byte, 8'hF1);
    slot(0, 0, 0); check("R6 legacy", out_byte, 8'h7F);
    status_en = 1;
    slot(1, 0, 0); check("R6 held legacy", out_byte, 8'h7F);

    // R7: sticky flags
    set_fields(0, 0, 0, 0);
    pulse(1, 0);
    frame_expect("R7 reported", 8'h00, 8'h08, 8'h00);
    frame_expect("R7 cleared", 8'h00, 8'h00, 8'h00);
    slot(0, 0, 1); check("R7 same cycle", out_byte, 8'h00);
    slot(1, 0, 0); check("R7 same cycle", out_byte, 8'h04);
    slot(2, 0, 0);

    // R8: legacy frames keep flags
    status_en = 0;
    pulse(1, 0);
    frame_expect("R8 legacy", 8'h7F, 8'h7F, 8'h7F);
    status_en = 1;
    frame_expect("R8 kept", 8'h00, 8'h08, 8'h00);

    // R2: slot index 3 ignored
    slot(3, 0, 0); check("R2 slot3", out_valid, 0);
    slot(2, 0, 0); check("R2 slot echo", out_slot, 2);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule